// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a synchronous SRAM that never wastes a bus cycle when the traffic turns between reads and writes. On a rising clock edge it samples the address, the operation type, the chip selects and the byte-write selects. The data transfer for that operation takes place in the clock cycle that follows. Read data reaches the output straight from the array, with no output register. Write data is taken from the data-in bus at the edge that closes its data cycle. Because every operation uses exactly one address cycle and one data cycle, a read can follow a write, or a write a read, on every clock.

The bus is presented as separate data-in, data-out and driver-enable signals. An external pad ring builds the bidirectional pins from them. A four-beat burst sequencer lets one loaded address serve a run of consecutive transfers. A static mode pin selects linear or interleaved beat order. A clock enable freezes the whole block. The storage depth is a parameter. The default is kept small for simulation, and `ADDR_W` = 17 gives the full 128K-word part.

Top module: `zbt_ft_sram`

## Requirements
- R1: A read that starts on edge k puts the array word at its address on `d_out` throughout the cycle after edge k. There is no output register, so a word written at edge k is already visible to a read whose address was captured at edge k.
- R2: A write that starts on edge k takes `d_in` at edge k+1 and stores it at the address captured on edge k.
- R3: Reads and writes may alternate on consecutive edges with no idle cycle, and every transfer keeps the one-cycle offset between address and data.
- R4: A word holds 36 bits. Byte lane n is made of bits [8n+7:8n] together with parity bit 32+n. `bw_n` is captured with the address, and only the lanes whose `bw_n[n]` bit was 0 are updated by the write.
- R5: `d_oe` is low during the data cycle of a write and during any cycle that carries no transfer.
- R6: `d_oe` is high only when a read is in its data cycle and `oe_n` is low. A high `oe_n` forces `d_oe` low at once, with no clock involved.
- R7: While `cen_n` is high, every synchronous input is ignored. Internal state and the array hold, and a pending transfer is held over until the next enabled edge.
- R8: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. If `ld_n`=0 on an edge where the device is not selected, no transfer starts and any burst ends, but a transfer already pending from the previous edge still completes.
- R9: With `ld_n`=1, a live burst advances: the next beat uses the same direction as the load. The two low address bits follow base+k (mod 4) when `seq_linear`=1, and they wrap within the aligned group of four.
- R10: With `seq_linear`=0, beat k uses the base low bits XOR k.
- R11: A synchronous low `rst_n` cancels any pending transfer and any burst, and it leaves the array contents untouched.
- R12: `ld_n`=1 while no burst is live starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | 0 loads a new address, 1 advances the burst |
| rd_wr | input | 1 | 1 read, 0 write; sampled on a load |
| addr | input | ADDR_W | Word address |
| bw_n | input | 4 | Byte-lane write selects, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | 36 | Write data |
| d_out | output | 36 | Read data, flow-through from the array |
| d_oe | output | 1 | Data driver enable for the pad ring |

## Verification
A wrong pipeline flag shows up on `d_oe` in the data cycle right after the faulty edge: the driver is either missing during a read or turned on during a write or a deselect. A corrupted address register, burst counter or lane mask shows up on `d_out` as soon as the affected word is read back. The bench therefore fills the whole small array and reads it back, sweeps all sixteen lane masks and every burst start in both beat orders, and compares each data cycle against a model in the bench. A clock-enable bug appears as data or driver state that changes across a frozen cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   localparam int LANES     = 4;
   localparam int LANE_BITS = 8;
   localparam int WORD_W    = LANES * (LANE_BITS + 1);
   localparam int BEAT_W    = 2;

   // beat k of a burst: low address bits derived from the loaded base
   function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] base,
                                                  input logic [BEAT_W-1:0] k,
                                                  input logic             linear);
      return linear ? BEAT_W'(base + k) : (base ^ k);
   endfunction

endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic              sel,
   input  logic              wr_in,
   input  logic [ADDR_W-1:0] base_in,
   input  logic              linear,
   output logic              live,
   output logic              burst_wr,
   output logic [ADDR_W-1:0] nxt_addr
);

   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] beat_nxt;

   assign beat_nxt = BEAT_W'(beat_q + 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live <= 1'b0;
      end else if (en) begin
         if (load) live <= sel;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         if (load) begin
            base_q   <= base_in;
            beat_q   <= '0;
            burst_wr <= wr_in;
         end else if (live) begin
            beat_q   <= beat_nxt;
         end
      end
   end

   assign nxt_addr = {base_q[ADDR_W-1:BEAT_W], beat_low(base_q[BEAT_W-1:0], beat_nxt, linear)};

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [LANES-1:0]  lane_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int DATA_W = LANES * LANE_BITS;

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      logic [LANE_BITS:0] ram [DEPTH];
      logic [LANE_BITS:0] wr_slice;

      assign wr_slice = {wdata[DATA_W+n], wdata[n*LANE_BITS +: LANE_BITS]};

      always_ff @(posedge clk) begin
         if (wr_en && !lane_n[n]) ram[addr] <= wr_slice;
      end

      assign rdata[n*LANE_BITS +: LANE_BITS] = ram[addr][LANE_BITS-1:0];
      assign rdata[DATA_W+n]                 = ram[addr][LANE_BITS];
   end

endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cen_n,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   input  logic              ld_n,
   input  logic              rd_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  bw_n,
   input  logic              seq_linear,
   input  logic              oe_n,
   input  logic [WORD_W-1:0] d_in,
   output logic [WORD_W-1:0] d_out,
   output logic              d_oe
);

   if (ADDR_W < BEAT_W) begin : g_bad_addr
      $error("zbt_ft_sram: ADDR_W must cover one burst group");
   end
   if (ADDR_W > 20) begin : g_big_addr
      $error("zbt_ft_sram: ADDR_W too large for a behavioural array");
   end

   logic              sel;
   logic              en;
   logic              b_live;
   logic              b_wr;
   logic [ADDR_W-1:0] b_addr;
   logic              issue;
   logic              issue_wr;
   logic [ADDR_W-1:0] issue_addr;

   // data-cycle stage
   logic              act_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0]  bw_q;

   assign sel        = !ce1_n && ce2 && !ce3_n;
   assign en         = !cen_n;
   assign issue      = ld_n ? b_live : sel;
   assign issue_wr   = ld_n ? b_wr : !rd_wr;
   assign issue_addr = ld_n ? b_addr : addr;

   zbt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .load     (!ld_n),
      .sel      (sel),
      .wr_in    (!rd_wr),
      .base_in  (addr),
      .linear   (seq_linear),
      .live     (b_live),
      .burst_wr (b_wr),
      .nxt_addr (b_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)  act_q <= 1'b0;
      else if (en) act_q <= issue;
   end

   always_ff @(posedge clk) begin
      if (en) begin
         wr_q   <= issue_wr;
         addr_q <= issue_addr;
         bw_q   <= bw_n;
      end
   end

   zbt_lane_array #(.ADDR_W(ADDR_W)) u_mem (
      .clk    (clk),
      .wr_en  (act_q && wr_q && en),
      .lane_n (bw_q),
      .addr   (addr_q),
      .wdata  (d_in),
      .rdata  (d_out)
   );

   assign d_oe = act_q && !wr_q && !oe_n;

endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cen_n,
   input logic        ce1_n,
   input logic        ce2,
   input logic        ce3_n,
   input logic        ld_n,
   input logic        rd_wr,
   input logic        oe_n,
   input logic [35:0] d_out,
   input logic        d_oe
);

   logic sel_w;
   assign sel_w = !ce1_n && ce2 && !ce3_n;

   assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !d_oe);

   assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && !ld_n && sel_w && !rd_wr) |=> !d_oe);

   assert_desel_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && !ld_n && !sel_w) |=> !d_oe);

   assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && !ld_n && sel_w && rd_wr) |=> (oe_n || d_oe));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cen_n |=> $stable(d_out));

   assert_reset_idle_R11: assert property (@(posedge clk)
      !rst_n |=> !d_oe);

endmodule

bind zbt_ft_sram zbt_ft_sram_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cen_n (cen_n),
   .ce1_n (ce1_n),
   .ce2   (ce2),
   .ce3_n (ce3_n),
   .ld_n  (ld_n),
   .rd_wr (rd_wr),
   .oe_n  (oe_n),
   .d_out (d_out),
   .d_oe  (d_oe)
);

// File: tb/tb_zbt_ft_sram.sv
module tb_zbt_ft_sram;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 4;
   localparam int DEPTH      = 1 << AW;
   localparam int WDOG       = 20000;
   localparam logic [2:0] SEL = 3'b010;   // {ce1_n, ce2, ce3_n}

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cen_n, ce1_n, ce2, ce3_n, ld_n, rd_wr, seq_linear, oe_n;
   logic [AW-1:0] addr;
   logic [3:0]    bw_n;
   logic [35:0]   d_in;
   logic [35:0]   d_out;
   logic          d_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   zbt_ft_sram #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .ld_n(ld_n), .rd_wr(rd_wr), .addr(addr), .bw_n(bw_n), .seq_linear(seq_linear),
      .oe_n(oe_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   int          wcnt = 0;
   string       tag = "R11";
   logic [35:0] model [DEPTH];
   logic          p_act = 1'b0, p_wr = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [3:0]    p_bw = '0;
   logic          b_live = 1'b0, b_wr = 1'b0;
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = '0;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk_bit(input string t, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s d_oe actual=%b expected=%b", t, act, exp);
      end
   endtask

   task automatic chk_word(input string t, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s d_out actual=%h expected=%h", t, act, exp);
      end
   endtask

   // compare outputs against the transfer the model holds in its data cycle
   task automatic check_out();
      logic exp_oe;
      exp_oe = p_act && !p_wr && !oe_n;
      chk_bit(tag, d_oe, exp_oe);
      if (exp_oe) chk_word(tag, d_out, model[p_addr]);
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input logic cen, input logic [2:0] ce, input logic ld,
                       input logic rw, input logic [AW-1:0] a, input logic [3:0] bw);
      logic [35:0] din;
      logic        s;
      check_out();
      din = {4'(wcnt) ^ 4'h5, 32'(wcnt) * 32'h9E37_79B1};
      wcnt++;
      cen_n = cen; {ce1_n, ce2, ce3_n} = ce; ld_n = ld; rd_wr = rw;
      addr = a; bw_n = bw; d_in = din;
      if (!cen) begin
         if (p_act && p_wr)
            for (int n = 0; n < 4; n++)
               if (!p_bw[n]) begin
                  model[p_addr][8*n +: 8] = din[8*n +: 8];
                  model[p_addr][32+n]     = din[32+n];
               end
         s = (ce == SEL);
         if (!ld) begin
            p_act = s; p_wr = !rw; p_addr = a;
            b_live = s; b_base = a; b_cnt = 2'd0; b_wr = !rw;
         end else if (b_live) begin
            b_cnt  = b_cnt + 2'd1;
            p_act  = 1'b1; p_wr = b_wr;
            p_addr = {b_base[AW-1:2],
                      seq_linear ? 2'(b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt)};
         end else begin
            p_act = 1'b0;
         end
         p_bw = bw;
      end
      @(negedge clk);
   endtask

   task automatic wr1(input logic [AW-1:0] a, input logic [3:0] bw);
      step(1'b0, SEL, 1'b0, 1'b0, a, bw);
   endtask
   task automatic rd1(input logic [AW-1:0] a);
      step(1'b0, SEL, 1'b0, 1'b1, a, 4'hF);
   endtask
   task automatic adv();
      step(1'b0, SEL, 1'b1, 1'b1, '0, 4'h0);
   endtask
   task automatic idle();
      step(1'b0, 3'b110, 1'b0, 1'b1, '0, 4'hF);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; cen_n = 1'b0; {ce1_n, ce2, ce3_n} = 3'b110; ld_n = 1'b0;
      rd_wr = 1'b1; addr = '0; bw_n = 4'hF; seq_linear = 1'b1; oe_n = 1'b0; d_in = '0;
      repeat (3) @(negedge clk);
      tag = "R11"; chk_bit(tag, d_oe, 1'b0);
      rst_n = 1'b1;

      // R12: advance with no live burst does nothing
      tag = "R12";
      step(1'b0, SEL, 1'b1, 1'b1, 4'd3, 4'h0);
      idle();

      // R2 / R1: fill every word, read every word
      tag = "R2";
      for (int i = 0; i < DEPTH; i++) wr1(AW'(i), 4'h0);
      tag = "R1";
      for (int i = 0; i < DEPTH; i++) rd1(AW'(DEPTH-1-i));
      idle();

      // R3: alternate with no gap, including read-after-write to the same word
      tag = "R3";
      for (int i = 0; i < DEPTH; i++) begin
         wr1(AW'(i), 4'h0);
         rd1(AW'(i));
         wr1(AW'(i+5), 4'h0);
         rd1(AW'(i+3));
      end
      idle();

      // R4: every lane mask on one word
      tag = "R4";
      for (int m = 0; m < 16; m++) begin
         wr1(AW'(6), 4'(m));
         rd1(AW'(6));
      end
      idle();

      // R9 / R10: read bursts from every start in both orders, with wrap
      for (int lin = 0; lin < 2; lin++) begin
         seq_linear = lin[0];
         tag = lin ? "R9" : "R10";
         for (int s = 0; s < 4; s++) begin
            rd1(AW'(8 + s));
            repeat (4) adv();
            step(1'b0, SEL, 1'b0, 1'b0, AW'(4 + s), 4'h0);
            repeat (3) step(1'b0, SEL, 1'b1, 1'b1, '0, 4'h0);
            rd1(AW'(4));
            rd1(AW'(5));
            rd1(AW'(6));
            rd1(AW'(7));
         end
         idle();
      end
      seq_linear = 1'b1;

      // R7: stalls hold a pending read and a pending write; inputs ignored
      tag = "R7";
      rd1(AW'(2));
      step(1'b1, SEL, 1'b0, 1'b0, AW'(9), 4'h0);
      step(1'b1, SEL, 1'b0, 1'b0, AW'(9), 4'h0);
      wr1(AW'(2), 4'h0);
      step(1'b1, SEL, 1'b0, 1'b1, AW'(11), 4'h0);
      step(1'b1, 3'b110, 1'b0, 1'b1, AW'(11), 4'h0);
      rd1(AW'(2));
      rd1(AW'(9));
      idle();

      // R8: each inactive enable ends a burst; pending transfer completes
      tag = "R8";
      for (int v = 0; v < 3; v++) begin
         logic [2:0] bad;
         bad = (v == 0) ? 3'b110 : (v == 1) ? 3'b000 : 3'b011;
         rd1(AW'(12));
         adv();
         step(1'b0, bad, 1'b0, 1'b1, AW'(0), 4'hF);
         adv();
         adv();
         wr1(AW'(13), 4'h0);
         step(1'b0, bad, 1'b0, 1'b0, AW'(0), 4'hF);
         adv();
         rd1(AW'(13));
         idle();
      end

      // R5: driver off in a write data cycle even with oe_n low
      tag = "R5";
      rd1(AW'(1));
      wr1(AW'(1), 4'h0);
      rd1(AW'(1));
      idle();

      // R6: asynchronous output enable inside a read data cycle
      tag = "R6";
      rd1(AW'(3));
      oe_n = 1'b1; #1;
      chk_bit("R6", d_oe, 1'b0);
      oe_n = 1'b0; #1;
      chk_bit("R6", d_oe, 1'b1);
      idle();

      // R11: reset mid-burst cancels the pending read and the burst
      tag = "R11";
      rd1(AW'(8));
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      p_act = 1'b0; b_live = 1'b0;
      check_out();
      adv();
      rd1(AW'(8));
      idle();
      idle();

      summary();
      $finish;
   end

endmodule